// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block schedules health checks of a backup battery and keeps their verdict on a low-battery indicator. A check is launched each time the main supply becomes valid, and again every time a long, fixed interval elapses while the supply stays valid. During a check the block raises a strobe that powers an external comparator. After a settle period it captures the comparator's digitized answer, which reads 1 when the battery is below the low threshold.

The verdict is held in a flag that drives the pull-down enable of an open-drain indicator pin. The flag is changed only by a completed check. It therefore keeps a low-battery warning through any stretch of battery-backup operation, until a later check finds the battery healthy. Nothing is monitored while the main supply is absent. The interval and the settle period are parameters, so a short interval can be used in simulation while silicon uses a day-long one.

Top module: `batt_low_monitor`

## Requirements
- R1: A check starts on the clock edge where `supply_ok` is sampled 1 after having been sampled 0 (the first valid sample after reset counts as well), so `check_en` is 1 from the following cycle.
- R2: While `supply_ok` stays 1, a new check starts every `INTERVAL_CYCLES` cycles, counted from the start of the previous check. The interval count restarts at zero at every power-up check.
- R3: `check_en` stays 1 for exactly `SETTLE_CYCLES` consecutive cycles per completed check. `batt_below` is captured only in the last of those cycles, and its value in every other cycle has no effect on the flag.
- R4: `low_pulldown` = 1 (drive the indicator pin low) after a check captures `batt_below` = 1. It returns to 0 only when a later check captures `batt_below` = 0.
- R5: While `supply_ok` is 0, `check_en` is 0 from the next cycle on. A check interrupted by loss of supply ends without changing `low_pulldown`.
- R6: `low_pulldown` keeps its value through any period with `supply_ok` = 0.
- R7: After reset, `check_en` = 0 and `low_pulldown` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | 1 while the main supply is within tolerance |
| batt_below | input | 1 | Digitized comparator output, 1 when the battery is below threshold |
| check_en | output | 1 | Comparator enable strobe, high for the settle period of a check |
| low_pulldown | output | 1 | 1 enables the pull-down of the open-drain battery-low pin |

## Verification
On every cycle, the assertions check the following: a power-up always starts a strobe, the strobe never runs past the settle period and never runs without supply, the flag moves only at the end of a strobe, and the flag takes the comparator value captured in the last settle cycle. Only the bench's scenarios can show the timing of the periodic re-check, including the restart of the interval at power-up. The same holds for the survival of a low verdict through a supply outage, the clearing of the flag by a later healthy check, and the immunity to comparator glitches outside the capture cycle. A cycle-level model in the bench compares both outputs throughout these scenarios.

// File: rtl/blm_pkg.sv
package blm_pkg;

    typedef enum logic {
        CHK_IDLE   = 1'b0,
        CHK_SETTLE = 1'b1
    } chk_state_e;

    // Counter width for a count running from 0 up to n-1, never below 1 bit.
    function automatic int cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/blm_interval_timer.sv
module blm_interval_timer
    import blm_pkg::*;
#(
    parameter int unsigned INTERVAL_CYCLES = 88_473_600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic pwr_up_o,
    output logic tick_o
);
    localparam int IW = cnt_width(INTERVAL_CYCLES);
    localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYCLES - 1);

    typedef struct packed {
        logic          sup;
        logic [IW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        tmr_d.sup = supply_ok;
        pwr_up_o = supply_ok & ~tmr_q.sup;
        tick_o   = supply_ok & tmr_q.sup & (tmr_q.cnt == LAST);
        if (pwr_up_o) begin
            tmr_d.cnt = '0;
        end else if (supply_ok) begin
            if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
            else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        // supply absent: counter frozen
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/blm_check_seq.sv
module blm_check_seq
    import blm_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic start_i,
    input  logic batt_below_i,
    output logic strobe_o,
    output logic flag_o
);
    localparam int SW = cnt_width(SETTLE_CYCLES);
    localparam logic [SW-1:0] LAST = SW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        chk_state_e    st;
        logic [SW-1:0] cnt;
        logic          flag;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            CHK_IDLE: begin
                if (start_i && supply_ok) begin
                    seq_d.st  = CHK_SETTLE;
                    seq_d.cnt = '0;
                end
            end
            CHK_SETTLE: begin
                if (!supply_ok) begin
                    seq_d.st = CHK_IDLE;          // aborted, verdict kept
                end else if (seq_q.cnt == LAST) begin
                    seq_d.st   = CHK_IDLE;
                    seq_d.flag = batt_below_i;    // capture in final settle cycle
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = CHK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= CHK_IDLE;
            seq_q.cnt  <= '0;
            seq_q.flag <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign strobe_o = (seq_q.st == CHK_SETTLE);
    assign flag_o   = seq_q.flag;

endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor #(
    parameter int unsigned INTERVAL_CYCLES = 88_473_600,
    parameter int unsigned SETTLE_CYCLES   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic batt_below,
    output logic check_en,
    output logic low_pulldown
);
    logic pwr_up;
    logic tick;

    blm_interval_timer #(
        .INTERVAL_CYCLES(INTERVAL_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .pwr_up_o (pwr_up),
        .tick_o   (tick)
    );

    blm_check_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .start_i     (pwr_up | tick),
        .batt_below_i(batt_below),
        .strobe_o    (check_en),
        .flag_o      (low_pulldown)
    );

endmodule

// File: rtl/batt_low_monitor_chk.sv
module batt_low_monitor_chk #(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic batt_below,
    input logic check_en,
    input logic low_pulldown
);
    logic        prev_sup;
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sup <= 1'b0;
            run_len  <= 0;
        end else begin
            prev_sup <= supply_ok;
            run_len  <= check_en ? run_len + 1 : 0;
        end
    end

    AST_POWERUP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !prev_sup) |=> check_en); // R1

    AST_STROBE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> (run_len < SETTLE_CYCLES)); // R3

    AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && supply_ok && run_len == SETTLE_CYCLES - 1)
        |=> (low_pulldown == $past(batt_below))); // R4

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !check_en |=> $stable(low_pulldown)); // R6

    AST_NO_STROBE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !check_en); // R5

endmodule

bind batt_low_monitor batt_low_monitor_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .batt_below  (batt_below),
    .check_en    (check_en),
    .low_pulldown(low_pulldown)
);

// File: tb/tb_batt_low_monitor.sv
`timescale 1ns/1ps
module tb_batt_low_monitor;
    localparam int INTERVAL = 40;
    localparam int SETTLE   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic batt_below = 1'b0;
    logic check_en;
    logic low_pulldown;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    batt_low_monitor #(
        .INTERVAL_CYCLES(INTERVAL),
        .SETTLE_CYCLES  (SETTLE)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .batt_below  (batt_below),
        .check_en    (check_en),
        .low_pulldown(low_pulldown)
    );

    // Behavioural reference: remaining strobe cycles, cycles since last start, verdict
    int m_left = 0;
    int m_int  = 0;
    bit m_prev = 0;
    bit m_flag = 0;
    int n_left, n_int;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_int = 0; m_prev = 0; m_flag = 0;
        end else begin
            n_left = m_left;
            n_int  = m_int;
            if (!supply_ok) begin
                n_left = 0;
            end else if (!m_prev) begin
                n_int  = 0;
                n_left = SETTLE;
            end else begin
                if (m_left > 0) begin
                    if (m_left == 1) m_flag = batt_below;
                    n_left = m_left - 1;
                end
                if (m_int == INTERVAL - 1) begin
                    n_int = 0;
                    if (m_left == 0) n_left = SETTLE;
                end else begin
                    n_int = m_int + 1;
                end
            end
            m_left = n_left;
            m_int  = n_int;
            m_prev = supply_ok;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(check_en == (m_left > 0), "R1/R2/R3/R5 check_en", check_en, m_left > 0);
            check(low_pulldown == m_flag, "R4/R6 low_pulldown", low_pulldown, m_flag);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    int start_seen;

    initial begin
        #3;
        cycles(4);
        @(negedge clk);
        check(check_en == 0, "R7 strobe in reset", check_en, 0);
        check(low_pulldown == 0, "R7 flag in reset", low_pulldown, 0);
        #1 rst_n = 1'b1;
        cycles(2);

        // R1: power-up with healthy battery
        supply_ok = 1'b1;
        cycles(1);
        @(negedge clk);
        check(check_en == 1, "R1 strobe after power-up", check_en, 1);
        cycles(SETTLE + 2);
        check(low_pulldown == 0, "R4 healthy verdict", low_pulldown, 0);

        // R2: battery goes low, periodic check catches it
        batt_below = 1'b1;
        start_seen = 0;
        for (int i = 0; i < INTERVAL + 2; i++) begin
            cycles(1);
            if (check_en && start_seen == 0) start_seen = i;
        end
        check(start_seen > 0, "R2 periodic check seen", start_seen, 1);
        cycles(SETTLE);
        check(low_pulldown == 1, "R4 low verdict latched", low_pulldown, 1);

        // R5/R6: outage with battery recovering, verdict held, no strobe
        supply_ok = 1'b0;
        batt_below = 1'b0;
        cycles(INTERVAL + 5);
        check(check_en == 0, "R5 no strobe unpowered", check_en, 0);
        check(low_pulldown == 1, "R6 verdict kept through outage", low_pulldown, 1);

        // R3: glitches on comparator except capture cycle; battery reads low only off-capture
        supply_ok = 1'b1;
        for (int i = 0; i < SETTLE + 1; i++) begin
            batt_below = (i < SETTLE - 1);
            cycles(1);
        end
        batt_below = 1'b0;
        cycles(2);
        check(low_pulldown == 0, "R3 only last cycle captured", low_pulldown, 0);

        // R3: high on capture cycle only sets flag
        cycles(INTERVAL - SETTLE - 3);
        for (int i = 0; i < SETTLE + 4; i++) begin
            batt_below = ~batt_below;
            cycles(1);
        end
        batt_below = 1'b1;
        cycles(INTERVAL);
        check(low_pulldown == 1, "R4 set by periodic check", low_pulldown, 1);

        // R5: supply lost mid-check with healthy battery, verdict unchanged
        batt_below = 1'b0;
        supply_ok = 1'b0;
        cycles(3);
        supply_ok = 1'b1;
        cycles(2);
        supply_ok = 1'b0;
        cycles(3);
        check(low_pulldown == 1, "R5 aborted check keeps verdict", low_pulldown, 1);

        // R2: counter restarted by power-up; next check a full interval later clears flag
        supply_ok = 1'b1;
        batt_below = 1'b1;
        cycles(SETTLE + 2);
        batt_below = 1'b0;
        cycles(INTERVAL - SETTLE - 4);
        check(check_en == 0, "R2 no early re-check", check_en, 0);
        cycles(SETTLE + 4);
        check(low_pulldown == 0, "R4 cleared by healthy check", low_pulldown, 0);

        cycles(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule